// File: doc/BRIEF.md
# Turbo Clock Ratio Step Controller

This block chooses the clock ratio of one chip in units of 100 MHz. One ratio is produced, and every active core on the chip runs at it. A periodic evaluation pulse arrives on `tick_i`, nominally once per millisecond. On each pulse the controller looks at three limit conditions: die temperature, a power flag and a current flag. It also looks at how many cores are active. It then moves the ratio by at most one step. Any exceeded limit pushes the ratio down. When every limit is clear, the ratio climbs toward a ceiling, and that ceiling falls as more cores become active.

Software supplies a baseline ratio, and this baseline is a hard floor. With turbo disabled the ratio simply tracks the baseline. With turbo enabled the ratio never drops below the baseline, even while limits stay exceeded. A status output shows when the floor is holding the ratio up against a limit. Two more outputs give a clear-to-boost indication and a one-cycle pulse whenever the ratio moves.

Top module: `turbo_ratio_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `ratio_o` equals the clamped baseline and `changed_o` is 0.
- R2: With `turbo_en_i` low, `ratio_o` takes the clamped baseline on the clock edge after the baseline is presented, whether or not a tick occurs.
- R3: With turbo enabled and the ratio at or above the floor, the ratio changes only on an edge where `tick_i` was high, and then by exactly one step.
- R4: The limit condition is true when `temp_i` (unsigned, degrees C) is 76 or more, or `pwr_over_i` is 1, or `cur_over_i` is 1. On a tick with the limit true and cores active, a ratio above the floor falls by one.
- R5: With turbo enabled, the ratio never drops below the floor. `clamp_o` is 1 exactly when turbo is enabled, cores are active, the limit is true and `ratio_o` equals the floor.
- R6: On a tick with no limit and cores active, a ratio below the ceiling rises by one.
- R7: The ceiling for an active-core count of 1, 2, 3 and 4 is 32, 31, 30 and 29. For any count of 5 or more it is 28.
- R8: When a larger core count lowers the ceiling below the present ratio, the ratio falls by one per tick until it reaches the ceiling. This happens even with no limit.
- R9: With an active-core count of 0, ticks leave the ratio unchanged, whatever the state of the limits.
- R10: `changed_o` is 1 for exactly the cycle in which `ratio_o` first shows a new value, and 0 otherwise.
- R11: The floor is the baseline clamped to the range 12..24. If the floor rises above the ratio with turbo enabled, the ratio jumps to the floor on the next edge, with or without a tick.
- R12: `boost_ok_o` is 1 exactly when turbo is enabled, cores are active and the limit is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle evaluation pulse |
| temp_i | input | 8 | Die temperature in degrees C |
| pwr_over_i | input | 1 | Power limit exceeded |
| cur_over_i | input | 1 | Current limit exceeded |
| base_ratio_i | input | 6 | Software baseline ratio, 100 MHz units |
| turbo_en_i | input | 1 | Enables stepping above the baseline |
| active_cores_i | input | 4 | Number of active cores |
| ratio_o | output | 6 | Chosen clock ratio, 100 MHz units |
| boost_ok_o | output | 1 | Clear to boost |
| clamp_o | output | 1 | Floor is holding the ratio against a limit |
| changed_o | output | 1 | Ratio moved on the last edge |

## Verification
The hardest situation to reach is a ratio sitting above a ceiling that has just been lowered. The ratio can only climb one step per tick, so the stimulus first drops the core count to one and ticks repeatedly until the ratio reaches 32. It then raises the count to two and then to twelve, with no limit present, so that each tick pulls the ratio down toward the new ceiling. A second hard case is pinning the ratio at the floor: a lowered baseline plus a sustained power limit drives the ratio step by step onto the floor, and further ticks must leave it there with the clamp status raised.

// File: rtl/turbo_pkg.sv
package turbo_pkg;
  localparam int RATIO_W_D    = 6;
  localparam int CORE_W_D     = 4;
  localparam int TEMP_W_D     = 8;
  localparam int TOP_RATIO_D  = 32;
  localparam int KNEE_CORES_D = 5;
  localparam int MIN_BASE_D   = 12;
  localparam int MAX_BASE_D   = 24;
  localparam int TEMP_LIMIT_D = 76;

  // ceiling for a given active-core count (count 0 uses the single-core value)
  function automatic int ceiling_for(input int cores, input int top, input int knee);
    if (cores <= 1)        return top;
    else if (cores >= knee) return top - knee + 1;
    else                   return top - cores + 1;
  endfunction
endpackage

// File: rtl/turbo_limit_eval.sv
module turbo_limit_eval #(
  parameter int TEMP_W     = turbo_pkg::TEMP_W_D,
  parameter int TEMP_LIMIT = turbo_pkg::TEMP_LIMIT_D
) (
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              pwr_over_i,
  input  logic              cur_over_i,
  output logic              limit_o
);
  localparam logic [TEMP_W-1:0] HOT = TEMP_W'(TEMP_LIMIT);

  logic temp_hot;

  always_comb begin
    temp_hot = (temp_i >= HOT);
    limit_o  = temp_hot | pwr_over_i | cur_over_i;
  end
endmodule

// File: rtl/turbo_bounds.sv
module turbo_bounds #(
  parameter int RATIO_W    = turbo_pkg::RATIO_W_D,
  parameter int CORE_W     = turbo_pkg::CORE_W_D,
  parameter int TOP_RATIO  = turbo_pkg::TOP_RATIO_D,
  parameter int KNEE_CORES = turbo_pkg::KNEE_CORES_D,
  parameter int MIN_BASE   = turbo_pkg::MIN_BASE_D,
  parameter int MAX_BASE   = turbo_pkg::MAX_BASE_D
) (
  input  logic [RATIO_W-1:0] base_i,
  input  logic [CORE_W-1:0]  cores_i,
  output logic [RATIO_W-1:0] floor_o,
  output logic [RATIO_W-1:0] ceil_o,
  output logic               idle_o
);
  localparam int N_CNT = 1 << CORE_W;
  localparam logic [RATIO_W-1:0] LO = RATIO_W'(MIN_BASE);
  localparam logic [RATIO_W-1:0] HI = RATIO_W'(MAX_BASE);

  logic [RATIO_W-1:0] ceil_tab [N_CNT];

  for (genvar n = 0; n < N_CNT; n++) begin : g_ceil
    localparam int CV = turbo_pkg::ceiling_for(n, TOP_RATIO, KNEE_CORES);
    assign ceil_tab[n] = RATIO_W'(CV);
  end

  always_comb begin
    if (base_i < LO)      floor_o = LO;
    else if (base_i > HI) floor_o = HI;
    else                  floor_o = base_i;
    ceil_o = ceil_tab[cores_i];
    idle_o = (cores_i == '0);
  end
endmodule

// File: rtl/turbo_step_core.sv
module turbo_step_core #(
  parameter int RATIO_W   = turbo_pkg::RATIO_W_D,
  parameter int TOP_RATIO = turbo_pkg::TOP_RATIO_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               en_i,
  input  logic               limit_i,
  input  logic               idle_i,
  input  logic [RATIO_W-1:0] floor_i,
  input  logic [RATIO_W-1:0] ceil_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               changed_o
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               seeded_q, seeded_d;
  logic               changed_q, changed_d;
  logic               step_en;

  // next-state
  always_comb begin
    ratio_d  = ratio_q;
    seeded_d = 1'b1;
    step_en  = seeded_q && en_i && (ratio_q >= floor_i) && tick_i && !idle_i;
    if (!seeded_q || !en_i || (ratio_q < floor_i)) begin
      ratio_d = floor_i;
    end else if (step_en) begin
      if (limit_i) begin
        if (ratio_q > floor_i) ratio_d = ratio_q - ONE;
      end else if (ratio_q < ceil_i) begin
        ratio_d = ratio_q + ONE;
      end else if ((ratio_q > ceil_i) && (ratio_q > floor_i)) begin
        ratio_d = ratio_q - ONE;
      end
    end
    changed_d = seeded_q && (ratio_d != ratio_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q   <= '0;
      seeded_q  <= 1'b0;
      changed_q <= 1'b0;
    end else begin
      ratio_q   <= ratio_d;
      seeded_q  <= seeded_d;
      changed_q <= changed_d;
    end
  end

  assign ratio_o   = seeded_q ? ratio_q : floor_i;
  assign changed_o = changed_q;

  // R3: without a tick, an enabled ratio at/above its floor holds
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seeded_q) && !$past(tick_i) && $past(en_i) && ($past(ratio_q) >= $past(floor_i)))
    |-> $stable(ratio_q));

  // R3: one step at most per edge once stepping is live
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seeded_q) && $past(en_i) && ($past(ratio_q) >= $past(floor_i)))
    |-> ($stable(ratio_q) || (ratio_q == $past(ratio_q) + ONE) || (ratio_q + ONE == $past(ratio_q))));

  // R4: a limit at a tick never lets the ratio rise
  a_r4_limit_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seeded_q) && $past(tick_i) && $past(limit_i) && $past(en_i) && ($past(ratio_q) >= $past(floor_i)))
    |-> (ratio_q <= $past(ratio_q)));

  // R7: never above the top ceiling
  a_r7_top_bound: assert property (@(posedge clk) disable iff (!rst_n)
    seeded_q |-> (ratio_q <= RATIO_W'(TOP_RATIO)));

  // R9: zero active cores freeze an enabled ratio
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seeded_q) && $past(idle_i) && $past(en_i) && ($past(ratio_q) >= $past(floor_i)))
    |-> $stable(ratio_q));

  // R10: no change pulse on the seeding edge after reset
  a_r10_no_pulse_at_seed: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(seeded_q) |-> !changed_q);
endmodule

// File: rtl/turbo_ratio_ctrl.sv
module turbo_ratio_ctrl #(
  parameter int RATIO_W    = turbo_pkg::RATIO_W_D,
  parameter int CORE_W     = turbo_pkg::CORE_W_D,
  parameter int TEMP_W     = turbo_pkg::TEMP_W_D,
  parameter int TOP_RATIO  = turbo_pkg::TOP_RATIO_D,
  parameter int KNEE_CORES = turbo_pkg::KNEE_CORES_D,
  parameter int MIN_BASE   = turbo_pkg::MIN_BASE_D,
  parameter int MAX_BASE   = turbo_pkg::MAX_BASE_D,
  parameter int TEMP_LIMIT = turbo_pkg::TEMP_LIMIT_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic               pwr_over_i,
  input  logic               cur_over_i,
  input  logic [RATIO_W-1:0] base_ratio_i,
  input  logic               turbo_en_i,
  input  logic [CORE_W-1:0]  active_cores_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               boost_ok_o,
  output logic               clamp_o,
  output logic               changed_o
);
  logic               limit;
  logic               idle;
  logic [RATIO_W-1:0] floor_r, ceil_r;

  turbo_limit_eval #(.TEMP_W(TEMP_W), .TEMP_LIMIT(TEMP_LIMIT)) u_limit (
    .temp_i     (temp_i),
    .pwr_over_i (pwr_over_i),
    .cur_over_i (cur_over_i),
    .limit_o    (limit)
  );

  turbo_bounds #(
    .RATIO_W(RATIO_W), .CORE_W(CORE_W), .TOP_RATIO(TOP_RATIO),
    .KNEE_CORES(KNEE_CORES), .MIN_BASE(MIN_BASE), .MAX_BASE(MAX_BASE)
  ) u_bounds (
    .base_i  (base_ratio_i),
    .cores_i (active_cores_i),
    .floor_o (floor_r),
    .ceil_o  (ceil_r),
    .idle_o  (idle)
  );

  turbo_step_core #(.RATIO_W(RATIO_W), .TOP_RATIO(TOP_RATIO)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .en_i      (turbo_en_i),
    .limit_i   (limit),
    .idle_i    (idle),
    .floor_i   (floor_r),
    .ceil_i    (ceil_r),
    .ratio_o   (ratio_o),
    .changed_o (changed_o)
  );

  always_comb begin
    boost_ok_o = turbo_en_i && !limit && !idle;
    clamp_o    = turbo_en_i && limit && !idle && (ratio_o == floor_r);
  end

  // R5: an enabled, settled ratio is never seen below the floor it was held to
  a_r5_floor_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(turbo_en_i) && $stable(base_ratio_i)) |-> (ratio_o >= floor_r));

  // R2: disabled turbo lands on the floor one edge later
  a_r2_follow_base: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(turbo_en_i) && $stable(base_ratio_i)) |-> (ratio_o == floor_r));
endmodule

// File: tb/tb_turbo_ratio_ctrl.sv
`timescale 1ns/1ps
module tb_turbo_ratio_ctrl;
  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [7:0] temp;
  logic       pwr, cur;
  logic [5:0] base;
  logic       en;
  logic [3:0] cores;
  logic [5:0] ratio;
  logic       boost, clamp, chg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  turbo_ratio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .temp_i(temp),
    .pwr_over_i(pwr), .cur_over_i(cur), .base_ratio_i(base),
    .turbo_en_i(en), .active_cores_i(cores), .ratio_o(ratio),
    .boost_ok_o(boost), .clamp_o(clamp), .changed_o(chg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic       tk;
    logic [7:0] tp;
    logic       pw;
    logic       cu;
    logic [5:0] bs;
    logic       e;
    logic [3:0] nc;
    logic [5:0] x_ratio;
    logic       x_chg;
    logic       x_boost;
    logic       x_clamp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 45;
  // tick temp pwr cur base en cores | ratio chg boost clamp | req
  localparam vec_t VEC [NV] = '{
    '{0,40,0,0,24,1,8, 24,0,1,0, 3},  // R3 no tick, hold
    '{1,40,0,0,24,1,8, 25,1,1,0, 6},  // R6 climb
    '{0,40,0,0,24,1,8, 25,0,1,0, 3},  // R3
    '{1,40,0,0,24,1,8, 26,1,1,0, 6},
    '{1,40,0,0,24,1,8, 27,1,1,0, 6},
    '{1,40,0,0,24,1,8, 28,1,1,0, 7},  // R7 reach 28 with 8 cores
    '{1,40,0,0,24,1,8, 28,0,1,0, 7},  // R7 capped
    '{1,40,0,0,24,1,4, 29,1,1,0, 7},  // R7 4 cores -> 29
    '{1,40,0,0,24,1,1, 30,1,1,0, 6},
    '{1,40,0,0,24,1,1, 31,1,1,0, 6},
    '{1,40,0,0,24,1,1, 32,1,1,0, 7},  // R7 1 core -> 32
    '{1,40,0,0,24,1,1, 32,0,1,0, 7},
    '{1,40,0,0,24,1,2, 31,1,1,0, 8},  // R8 ceiling drop, no limit
    '{1,40,0,0,24,1,12,30,1,1,0, 8},  // R8
    '{0,40,0,0,24,1,12,30,0,1,0, 3},  // R3
    '{1,40,0,0,24,1,12,29,1,1,0, 8},
    '{1,40,0,0,24,1,12,28,1,1,0, 8},
    '{1,40,0,0,24,1,12,28,0,1,0, 10}, // R10 no move, no pulse
    '{1,76,0,0,24,1,8, 27,1,0,0, 4},  // R4 temperature at threshold
    '{1,75,0,0,24,1,8, 28,1,1,0, 4},  // R4 just below threshold
    '{1,40,1,0,24,1,8, 27,1,0,0, 4},  // R4 power flag
    '{1,40,0,1,24,1,8, 26,1,0,0, 4},  // R4 current flag
    '{0,40,0,1,24,1,8, 26,0,0,0, 12}, // R12 boost low under limit
    '{1,40,0,1,24,1,8, 25,1,0,0, 4},
    '{1,40,0,1,25,1,8, 24,1,0,1, 5},  // R5 base 25 clamps to 24, at floor
    '{1,40,0,1,25,1,8, 24,0,0,1, 5},  // R5 pinned at floor
    '{1,40,0,0,24,1,8, 25,1,1,0, 6},
    '{1,40,0,0,24,1,0, 25,0,0,0, 9},  // R9 zero cores hold
    '{1,90,0,0,24,1,0, 25,0,0,0, 9},  // R9 limit ignored with zero cores
    '{1,40,0,0,20,1,8, 26,1,1,0, 6},
    '{1,40,1,0,20,1,8, 25,1,0,0, 4},
    '{1,40,1,0,20,1,8, 24,1,0,0, 4},
    '{1,40,1,0,20,1,8, 23,1,0,0, 4},
    '{1,40,1,0,20,1,8, 22,1,0,0, 4},
    '{1,40,1,0,20,1,8, 21,1,0,0, 4},
    '{1,40,1,0,20,1,8, 20,1,0,1, 5},  // R5 reaches floor 20
    '{1,40,1,0,20,1,8, 20,0,0,1, 5},  // R5
    '{1,40,1,0,5, 1,8, 19,1,0,0, 11}, // R11 base 5 -> floor 12
    '{0,40,0,0,5, 0,8, 12,1,0,0, 2},  // R2 disabled -> floor 12
    '{1,40,0,0,18,0,8, 18,1,0,0, 2},  // R2
    '{0,40,0,0,18,0,8, 18,0,0,0, 10}, // R10
    '{0,40,0,0,22,1,8, 22,1,1,0, 11}, // R11 floor above ratio, jump
    '{0,40,0,0,22,1,8, 22,0,1,0, 11},
    '{0,40,0,0,30,1,8, 24,1,1,0, 11}, // R11 base 30 -> floor 24
    '{1,40,0,0,30,1,8, 25,1,1,0, 6}
  };

  task automatic check(input string what, input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R0 watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; temp = 8'd40; pwr = 0; cur = 0;
    base = 6'd24; en = 1; cores = 4'd8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("reset ratio", 1, ratio, 24);
    check("reset changed", 1, chg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("ratio after release (R1)", 1, ratio, 24);
    check("changed after release (R1)", 1, chg, 0);

    for (int i = 0; i < NV; i++) begin
      tick = VEC[i].tk; temp = VEC[i].tp; pwr = VEC[i].pw; cur = VEC[i].cu;
      base = VEC[i].bs; en = VEC[i].e; cores = VEC[i].nc;
      @(posedge clk);
      @(negedge clk);
      tick = 0;
      check($sformatf("vec %0d ratio", i), VEC[i].req, ratio, VEC[i].x_ratio);
      check($sformatf("vec %0d changed", i), VEC[i].req, chg, VEC[i].x_chg);
      check($sformatf("vec %0d boost", i), VEC[i].req, boost, VEC[i].x_boost);
      check($sformatf("vec %0d clamp", i), VEC[i].req, clamp, VEC[i].x_clamp);
    end

    // R1: reset in mid-run with a new baseline
    base = 6'd16; en = 1; tick = 0; pwr = 0; cur = 0; temp = 8'd40;
    rst_n = 1'b0;
    #1;
    check("mid-run reset ratio (R1)", 1, ratio, 16);
    check("mid-run reset changed (R1)", 1, chg, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("ratio after second release (R1)", 1, ratio, 16);
    check("no pulse on seeding (R10)", 10, chg, 0);
    // R10: pulse lasts a single cycle
    tick = 1; @(posedge clk); @(negedge clk); tick = 0;
    check("step after reset (R6)", 6, ratio, 17);
    check("pulse high (R10)", 10, chg, 1);
    @(posedge clk); @(negedge clk);
    check("pulse gone (R10)", 10, chg, 0);
    check("held without tick (R3)", 3, ratio, 17);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule